// File: doc/BRIEF.md
# Eight-Channel Double-Buffered Converter Command Bank

This block accepts decoded 16-bit command words for an eight-channel digital-to-analog converter and keeps the digital state behind the converter. Each channel has two 8-bit registers: a staging (input) register and a live (output) register that drives the converter code. The block also holds one output-enable bit per channel, a full-shutdown flag and the serial-output phase bit. A word is accepted on a rising clock edge while its valid strobe is high. An active-low load pin, while held low, makes every live register follow its staging register.

Each word carries a 3-bit channel address in bits 13:11, a 3-bit operation code in bits 10:8 and a data byte in bits 7:0. Bits 15:14 are ignored. Eight operations are available. There is a pass-through operation, used when several converters share one serial chain. The others are: zero everything; mask channel enables; select the output phase with a global update; broadcast the byte to every live register; stage the byte; write one channel's staging and live registers; and a global update. Channel n drives `dac_code[8n+7:8n]` and `chan_en[n]`.

Top module: `dac_cmd_bank`

## Requirements
- R1: While rst_n is low (asynchronous), every dac_code byte is 0x00, chan_en is 0xFF, full_sd is 0 and phase_rise is 0.
- R2: Operation 000 (no-op) changes no register: codes, enables, full_sd and phase_rise keep their values.
- R3: Operation 001 zeroes every staging and live register, sets chan_en to 0xFF and clears full_sd. phase_rise is unchanged.
- R4: Operation 010 loads chan_en with the data byte, where bit n enables channel n. full_sd is 1 exactly when that byte is 0x00. Codes are unchanged.
- R5: Operation 011 sets phase_rise to address bit 2, which is word bit 13 (0 = falling edge, 1 = rising edge). Address bits 1:0 are ignored. The operation also copies every staging register into its live register, and it does not change enables or full_sd.
- R6: Operation 100 writes the data byte into all eight live registers and leaves staging registers unchanged. It sets chan_en to 0xFF and clears full_sd. On the edge where it is taken, it has priority over transparency.
- R7: Operation 101 writes the data byte into the staging register of the addressed channel. No live register, enable or full_sd changes.
- R8: Operation 110 writes the data byte into both the staging and the live register of the addressed channel. It sets chan_en to 0xFF and clears full_sd.
- R9: Operation 111 copies every staging register into its live register and does not change enables, full_sd or phase_rise.
- R10: On every clock edge where load_n is low, each live register takes its staging register's new value, except on an edge that applies operation 100 or 001.
- R11: phase_rise changes only on reset or on operation 011.
- R12: A word presented with cmd_valid low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_word | input | 16 | Command word: [13:11] address, [10:8] operation, [7:0] data |
| cmd_valid | input | 1 | Word is taken on this clock edge when high |
| load_n | input | 1 | Active-low level load; live registers follow staging while low |
| dac_code | output | 64 | Live codes, channel n in bits [8n+7:8n] |
| chan_en | output | 8 | Per-channel output-enable bits |
| full_sd | output | 1 | High when every channel is disabled by a shutdown word |
| phase_rise | output | 1 | Serial-output phase: 0 falling edge, 1 rising edge |

## Verification
The hardest states to reach are the hidden staging values, because they can only be seen after a copy. The stimulus stages distinct bytes in several channels and leaves the live registers stale. A global update or a phase operation then exposes the staged bytes. Shutdown and wake-up are checked as a sequence: a mask, then a full shutdown, then a non-waking staging write, then a waking broadcast. The load pin is held low across a staging write, a broadcast and an idle cycle. This shows the broadcast winning on its own edge and transparency restoring the staged values on the next edge.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;

   localparam int CTRL_W = 3;

   typedef enum logic [CTRL_W-1:0] {
      OP_NOP      = 3'd0,
      OP_CLEAR    = 3'd1,
      OP_SHDN     = 3'd2,
      OP_PHASE    = 3'd3,
      OP_LOAD_ALL = 3'd4,
      OP_WR_IN    = 3'd5,
      OP_WR_BOTH  = 3'd6,
      OP_UPDATE   = 3'd7
   } op_e;

endpackage

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
   import dac_cmd_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int DATA_W = 8,
   parameter int ADDR_W = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [ADDR_W+CTRL_W+DATA_W-1:0] fields,
   input  logic                       valid,
   output logic [NUM_CH-1:0]          in_we,
   output logic [NUM_CH-1:0]          out_we,
   output logic                       clear_all,
   output logic                       copy_all,
   output logic                       wake,
   output logic                       sd_load,
   output logic                       phase_load,
   output logic                       phase_val,
   output logic [DATA_W-1:0]          data
);

   logic [ADDR_W-1:0] addr;
   op_e               op;
   logic [NUM_CH-1:0] sel;

   assign data = fields[DATA_W-1:0];
   assign op   = op_e'(fields[DATA_W +: CTRL_W]);
   assign addr = fields[DATA_W+CTRL_W +: ADDR_W];

   initial begin
      param_addr_chk: assert (NUM_CH <= (1 << ADDR_W))
         else $fatal(1, "address field too narrow for channel count");
      param_phase_chk: assert (ADDR_W >= 1)
         else $fatal(1, "phase select needs an address bit");
   end

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_sel
      assign sel[ch] = (addr == ADDR_W'(ch));
   end

   always_comb begin
      in_we      = '0;
      out_we     = '0;
      clear_all  = 1'b0;
      copy_all   = 1'b0;
      wake       = 1'b0;
      sd_load    = 1'b0;
      phase_load = 1'b0;
      phase_val  = addr[ADDR_W-1];
      if (valid) begin
         unique case (op)
            OP_NOP:      ;
            OP_CLEAR:    begin clear_all = 1'b1; wake = 1'b1; end
            OP_SHDN:     sd_load = 1'b1;
            OP_PHASE:    begin phase_load = 1'b1; copy_all = 1'b1; end
            OP_LOAD_ALL: begin out_we = '1; wake = 1'b1; end
            OP_WR_IN:    in_we = sel;
            OP_WR_BOTH:  begin in_we = sel; out_we = sel; wake = 1'b1; end
            OP_UPDATE:   copy_all = 1'b1;
            default:     ;
         endcase
      end
   end

   // R7
   sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(in_we));

   // R2
   nop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && op == OP_NOP) |-> !(|in_we || |out_we || clear_all || copy_all || wake || sd_load || phase_load));

endmodule

// File: rtl/dac_chan_slice.sv
module dac_chan_slice #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_we,
   input  logic              out_we,
   input  logic              clear,
   input  logic              copy,
   input  logic              xpar,
   input  logic [DATA_W-1:0] data,
   output logic [DATA_W-1:0] out_code
);

   logic [DATA_W-1:0] in_q, in_d, out_d;

   always_comb begin
      if (clear)      in_d = '0;
      else if (in_we) in_d = data;
      else            in_d = in_q;

      if (clear)              out_d = '0;
      else if (out_we)        out_d = data;
      else if (copy || xpar)  out_d = in_d;
      else                    out_d = out_code;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_q     <= '0;
         out_code <= '0;
      end else begin
         in_q     <= in_d;
         out_code <= out_d;
      end
   end

   // R7
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(clear || out_we || copy || xpar) |=> $stable(out_code));

   // R10
   xpar_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xpar && !out_we && !clear) |=> (out_code == in_q));

   // R6
   direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_we && !clear) |=> (out_code == $past(data)));

   // R3
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (out_code == '0 && in_q == '0));

endmodule

// File: rtl/dac_power_ctrl.sv
module dac_power_ctrl #(
   parameter int NUM_CH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wake,
   input  logic              sd_load,
   input  logic [NUM_CH-1:0] sd_mask,
   input  logic              phase_load,
   input  logic              phase_val,
   output logic [NUM_CH-1:0] chan_en,
   output logic              full_sd,
   output logic              phase_rise
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chan_en <= '1;
         full_sd <= 1'b0;
      end else if (wake) begin
         chan_en <= '1;
         full_sd <= 1'b0;
      end else if (sd_load) begin
         chan_en <= sd_mask;
         full_sd <= (sd_mask == '0);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          phase_rise <= 1'b0;
      else if (phase_load) phase_rise <= phase_val;
   end

   // R3
   wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake |=> (&chan_en && !full_sd));

   // R4
   mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_load && !wake) |=> (chan_en == $past(sd_mask) && full_sd == ($past(sd_mask) == '0)));

   // R11
   phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !phase_load |=> $stable(phase_rise));

   // R9
   en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wake || sd_load) |=> ($stable(chan_en) && $stable(full_sd)));

endmodule

// File: rtl/dac_cmd_bank.sv
module dac_cmd_bank
   import dac_cmd_pkg::*;
#(
   parameter  int NUM_CH      = 8,
   parameter  int DATA_W      = 8,
   parameter  int ADDR_W      = 3,
   parameter  int PAD_W       = 2,
   parameter  int SYNC_STAGES = 0,
   localparam int FIELD_W     = ADDR_W + CTRL_W + DATA_W,
   localparam int WORD_W      = PAD_W + FIELD_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [WORD_W-1:0]        cmd_word,
   input  logic                     cmd_valid,
   input  logic                     load_n,
   output logic [NUM_CH*DATA_W-1:0] dac_code,
   output logic [NUM_CH-1:0]        chan_en,
   output logic                     full_sd,
   output logic                     phase_rise
);

   logic [NUM_CH-1:0] in_we, out_we;
   logic              clear_all, copy_all, wake, sd_load, phase_load, phase_val;
   logic [DATA_W-1:0] data;
   logic              xpar;

   initial begin
      param_mask_chk: assert (DATA_W >= NUM_CH)
         else $fatal(1, "data byte must cover one enable bit per channel");
      param_pad_chk: assert (PAD_W >= 0 && SYNC_STAGES >= 0)
         else $fatal(1, "negative pad or sync depth");
   end

   if (PAD_W > 0) begin : g_pad
      logic unused_pad;
      assign unused_pad = ^cmd_word[WORD_W-1:FIELD_W];
   end

   if (SYNC_STAGES == 0) begin : g_load_direct
      assign xpar = ~load_n;
   end else begin : g_load_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '1;
         else        sync_q <= {sync_q[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], load_n} ;
      end
      assign xpar = ~sync_q[SYNC_STAGES-1];
   end

   dac_cmd_decode #(
      .NUM_CH (NUM_CH),
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) i_decode (
      .clk        (clk),
      .rst_n      (rst_n),
      .fields     (cmd_word[FIELD_W-1:0]),
      .valid      (cmd_valid),
      .in_we      (in_we),
      .out_we     (out_we),
      .clear_all  (clear_all),
      .copy_all   (copy_all),
      .wake       (wake),
      .sd_load    (sd_load),
      .phase_load (phase_load),
      .phase_val  (phase_val),
      .data       (data)
   );

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
      dac_chan_slice #(
         .DATA_W (DATA_W)
      ) i_slice (
         .clk      (clk),
         .rst_n    (rst_n),
         .in_we    (in_we[ch]),
         .out_we   (out_we[ch]),
         .clear    (clear_all),
         .copy     (copy_all),
         .xpar     (xpar),
         .data     (data),
         .out_code (dac_code[ch*DATA_W +: DATA_W])
      );
   end

   dac_power_ctrl #(
      .NUM_CH (NUM_CH)
   ) i_power (
      .clk        (clk),
      .rst_n      (rst_n),
      .wake       (wake),
      .sd_load    (sd_load),
      .sd_mask    (data[NUM_CH-1:0]),
      .phase_load (phase_load),
      .phase_val  (phase_val),
      .chan_en    (chan_en),
      .full_sd    (full_sd),
      .phase_rise (phase_rise)
   );

   // R12
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_valid && !xpar) |=> ($stable(dac_code) && $stable(chan_en) && $stable(phase_rise)));

endmodule

// File: tb/test_dac_cmd_bank.sv
`timescale 1ns/1ps
module test_dac_cmd_bank;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cmd_word = '0;
   logic        cmd_valid = 1'b0;
   logic        load_n = 1'b1;
   logic [63:0] dac_code;
   logic [7:0]  chan_en;
   logic        full_sd;
   logic        phase_rise;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   dac_cmd_bank i_dac_cmd_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_word   (cmd_word),
      .cmd_valid  (cmd_valid),
      .load_n     (load_n),
      .dac_code   (dac_code),
      .chan_en    (chan_en),
      .full_sd    (full_sd),
      .phase_rise (phase_rise)
   );

   function automatic logic [15:0] mk(input logic [2:0] a, input logic [2:0] op, input logic [7:0] d);
      return {2'b00, a, op, d};
   endfunction

   typedef struct packed {
      logic        valid;
      logic        ldn;
      logic [15:0] word;
      logic [2:0]  ch;
      logic [7:0]  code;
      logic [7:0]  en;
      logic        sd;
      logic        ph;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 1'b1, mk(3'd3, 3'd5, 8'h5A), 3'd3, 8'h00, 8'hFF, 1'b0, 1'b0}, // R7 stage ch3
      '{1'b1, 1'b1, mk(3'd7, 3'd5, 8'hC3), 3'd7, 8'h00, 8'hFF, 1'b0, 1'b0}, // R7 stage ch7
      '{1'b1, 1'b1, mk(3'd2, 3'd7, 8'h9E), 3'd3, 8'h5A, 8'hFF, 1'b0, 1'b0}, // R9 update
      '{1'b1, 1'b1, mk(3'd5, 3'd0, 8'hFF), 3'd7, 8'hC3, 8'hFF, 1'b0, 1'b0}, // R2 no-op
      '{1'b1, 1'b1, mk(3'd0, 3'd2, 8'hA5), 3'd3, 8'h5A, 8'hA5, 1'b0, 1'b0}, // R4 mask
      '{1'b1, 1'b1, mk(3'd0, 3'd7, 8'h00), 3'd7, 8'hC3, 8'hA5, 1'b0, 1'b0}, // R9 no wake
      '{1'b1, 1'b1, mk(3'd1, 3'd6, 8'h77), 3'd1, 8'h77, 8'hFF, 1'b0, 1'b0}, // R8 write both
      '{1'b1, 1'b1, mk(3'd4, 3'd2, 8'h00), 3'd1, 8'h77, 8'h00, 1'b1, 1'b0}, // R4 full shutdown
      '{1'b1, 1'b1, mk(3'd0, 3'd5, 8'h11), 3'd0, 8'h00, 8'h00, 1'b1, 1'b0}, // R7 no wake
      '{1'b1, 1'b1, mk(3'd6, 3'd4, 8'h3C), 3'd5, 8'h3C, 8'hFF, 1'b0, 1'b0}, // R6 broadcast
      '{1'b1, 1'b1, mk(3'd4, 3'd3, 8'hE1), 3'd5, 8'h00, 8'hFF, 1'b0, 1'b1}, // R5 rising + copy
      '{1'b1, 1'b1, mk(3'd3, 3'd1, 8'h6B), 3'd3, 8'h00, 8'hFF, 1'b0, 1'b1}, // R3 clear, R11 phase kept
      '{1'b1, 1'b1, mk(3'd0, 3'd2, 8'h0F), 3'd0, 8'h00, 8'h0F, 1'b0, 1'b1}, // R4 partial mask
      '{1'b1, 1'b1, mk(3'd0, 3'd1, 8'h00), 3'd0, 8'h00, 8'hFF, 1'b0, 1'b1}, // R3 wake
      '{1'b1, 1'b1, mk(3'd3, 3'd3, 8'h00), 3'd3, 8'h00, 8'hFF, 1'b0, 1'b0}, // R5 falling, A1A0 ignored
      '{1'b1, 1'b0, mk(3'd2, 3'd5, 8'h99), 3'd2, 8'h99, 8'hFF, 1'b0, 1'b0}, // R10 transparent stage
      '{1'b1, 1'b0, mk(3'd0, 3'd4, 8'h44), 3'd4, 8'h44, 8'hFF, 1'b0, 1'b0}, // R6 broadcast wins
      '{1'b0, 1'b0, mk(3'd2, 3'd6, 8'hEE), 3'd4, 8'h00, 8'hFF, 1'b0, 1'b0}, // R10 follow, R12 ignored
      '{1'b0, 1'b1, mk(3'd0, 3'd4, 8'hEE), 3'd2, 8'h99, 8'hFF, 1'b0, 1'b0}  // R12 ignored word
   };

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 5000 && !done) begin
         done = 1'b1;
         failures++;
         $display("FAIL watchdog actual=%0d expected=<5000", cycles);
         finish_run();
      end
   end

   initial begin
      // R1 reset state
      repeat (2) @(negedge clk);
      for (int c = 0; c < 8; c++) chk($sformatf("R1 code ch%0d", c), dac_code[c*8 +: 8], 8'h00);
      chk("R1 chan_en", chan_en, 8'hFF);
      chk("R1 full_sd", {7'd0, full_sd}, 8'h00);
      chk("R1 phase", {7'd0, phase_rise}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         cmd_word  = VEC[i].word;
         cmd_valid = VEC[i].valid;
         load_n    = VEC[i].ldn;
         @(negedge clk);
         chk($sformatf("vec%0d code ch%0d", i, VEC[i].ch), dac_code[VEC[i].ch*8 +: 8], VEC[i].code);
         chk($sformatf("vec%0d chan_en", i), chan_en, VEC[i].en);
         chk($sformatf("vec%0d full_sd", i), {7'd0, full_sd}, {7'd0, VEC[i].sd});
         chk($sformatf("vec%0d phase", i), {7'd0, phase_rise}, {7'd0, VEC[i].ph});
      end
      cmd_valid = 1'b0;
      load_n    = 1'b1;

      // R5 broadcast, then staged copy restores: stage ch6, copy, see broadcast replaced
      cmd_word = mk(3'd6, 3'd5, 8'hB4); cmd_valid = 1'b1;
      @(negedge clk);
      chk("R7 ch6 live stale", dac_code[6*8 +: 8], 8'h00);
      cmd_word = mk(3'd7, 3'd3, 8'h00);
      @(negedge clk);
      chk("R5 ch6 copied", dac_code[6*8 +: 8], 8'hB4);
      chk("R5 ch2 copied", dac_code[2*8 +: 8], 8'h99);
      chk("R5 phase rising", {7'd0, phase_rise}, 8'h01);

      // R1 asynchronous reset mid-run
      cmd_word = mk(3'd0, 3'd2, 8'h33);
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R4 mask 33", chan_en, 8'h33);
      #1 rst_n = 1'b0;
      #0.5;
      chk("R1 async code ch6", dac_code[6*8 +: 8], 8'h00);
      chk("R1 async chan_en", chan_en, 8'hFF);
      chk("R1 async phase", {7'd0, phase_rise}, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 phase stays low through non-phase words
      cmd_word = mk(3'd4, 3'd7, 8'h00); cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R11 phase after update", {7'd0, phase_rise}, 8'h00);

      done = 1'b1;
      finish_run();
   end

endmodule